// File: doc/BRIEF.md
# Programmable Infrared Pulse-Distance Decoder

This block turns a demodulated one-bit infrared receiver signal into a message word of up to 48 bits. It times every mark (the active pulse) and every full symbol (mark plus the following space, measured from one rising mark edge to the next) in clock cycles. It then compares both measures against programmable windows. One window set describes the optional leader symbol, and four window sets describe the data symbols. Each accepted data symbol adds one bit to a 64-bit shift register. When the line stays idle for at least a programmable free time, the message ends. The block keeps it only if its bit count lies inside a programmable length range.

Software programs the timing windows and the mode bits through a simple write port. It reads the captured message as a low and a high 32-bit word, together with the bit count and a valid flag. The valid flag protects the captured message: while it is set, no later message can replace it, and it drops only when software writes the status register with its flag bit at zero.

Top module: `irPdDecoder`

## Requirements
- R1: With leader detection on (control bit 2), a frame starts only after a leader symbol where floor(width/16) lies inclusively between leader fields wMin..wMax and floor(period/16) lies inclusively between pMin..pMax. Any other leader is dropped.
- R2: A data symbol matches window k (k = 0..3, addresses 2..5) when width in cycles lies in wMin..wMax and floor(period/2) lies in pMin..pMax, bounds included. An even k gives bit 0 and an odd k gives bit 1. When several windows match, the lowest k wins. Every window word holds wMin in bits 7:0, wMax in bits 15:8, pMin in bits 23:16 and pMax in bits 31:24.
- R3: A data symbol that matches no window aborts the frame, and no valid message results from it. Decoding resumes at the next good leader, or at the next symbol when the leader is off.
- R4: While a frame is in progress, a space with floor(spaceCycles/8) at least equal to the free-time field (address 6, bits 7:0) ends the message. A shorter space does not end it.
- R5: The minimum length is the 5-bit field at address 6, bits 12:8, with bit 0 forced to zero. The maximum length is the field in bits 21:16, rounded up to an even value and limited to 48. A message whose bit count falls outside [min, max] is discarded, and a captured length never exceeds 48.
- R6: With control bit 3 at zero, decoded bit i lands at data bit i. With it at one, the first bit of an n-bit message lands at bit n-1 and the last bit at bit 0.
- R7: With control bit 4 set, every decoded bit is stored inverted.
- R8: With control bit 1 set, a low level on the input counts as a mark.
- R9: The valid flag stays set until a write to address 7 with bit 0 at zero clears it. A write to address 7 with bit 0 at one has no effect. While the flag is set, the data and length outputs hold and later messages are dropped.
- R10: With control bit 0 (decode enable) at zero, nothing is decoded and any partial frame is thrown away. Outputs that were already captured are kept.
- R11: With leader detection off, the first rising mark edge starts the first data symbol.
- R12: After reset the valid flag, the length and both data words are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| irIn | input | 1 | Demodulated infrared level |
| cfgWrEn | input | 1 | Register write strobe |
| cfgAddr | input | 3 | Register address (0 control, 1 leader, 2..5 data windows, 6 free time and lengths, 7 status) |
| cfgWrData | input | 32 | Register write data |
| rxDataLo | output | 32 | Captured message bits 31:0 |
| rxDataHi | output | 32 | Captured message bits 63:32 |
| rxLen | output | 6 | Captured message bit count |
| rxValid | output | 1 | A captured message is waiting |

## Verification
The bench sweeps every message length from 1 to 50 bits against a length range of 4..48. A design that rounded the length fields wrongly, or that kept the unclamped maximum, would accept or reject lengths at the edges of the range. Symbol widths and periods are set one step inside and one step outside each window bound. This exposes designs with exclusive bounds or off-by-one unit shifts, which would drop good frames or accept bad ones. Overlapping windows show whether the lowest index decides the bit value. A second message sent while valid is still set shows whether a design overwrites unread data. A decode disable in the middle of a frame shows whether a design completes a frame it should have thrown away.

// File: rtl/irPdPkg.sv
`timescale 1ns/1ps
package irPdPkg;
  localparam int FIELD_W     = 8;
  localparam int NUM_DSYM    = 4;
  localparam int DATA_W      = 64;
  localparam int LEN_W       = 6;
  localparam int MIN_LEN_W   = 5;
  localparam int CNT_W       = 12;
  localparam int ADDR_W      = 3;
  localparam int REG_W       = 32;
  localparam int LEAD_SHIFT  = 4;
  localparam int DPER_SHIFT  = 1;
  localparam int DWID_SHIFT  = 0;
  localparam int FREE_SHIFT  = 3;
  localparam int MAX_LEN_CAP = 48;
  localparam int FREE_MINLEN_LSB = 8;
  localparam int FREE_MAXLEN_LSB = 16;

  localparam logic [ADDR_W-1:0] ADDR_CTRL   = 3'd0;
  localparam logic [ADDR_W-1:0] ADDR_LEAD   = 3'd1;
  localparam logic [ADDR_W-1:0] ADDR_SYM0   = 3'd2;
  localparam logic [ADDR_W-1:0] ADDR_FREE   = 3'd6;
  localparam logic [ADDR_W-1:0] ADDR_STATUS = 3'd7;

  typedef struct packed {
    logic [FIELD_W-1:0] pMax;
    logic [FIELD_W-1:0] pMin;
    logic [FIELD_W-1:0] wMax;
    logic [FIELD_W-1:0] wMin;
  } symWin_t;

  typedef struct packed {
    logic decodeEn;
    logic polInv;
    logic leaderEn;
    logic msbFirst;
    logic bitInv;
    symWin_t lead;
    symWin_t [NUM_DSYM-1:0] sym;
    logic [FIELD_W-1:0] freeMin;
    logic [LEN_W-1:0] minLen;
    logic [LEN_W-1:0] maxLen;
  } cfg_t;

  typedef struct packed {
    logic frameClr;
    logic shiftEn;
    logic commit;
  } ctlStrobe_t;

  typedef enum logic [1:0] {ST_IDLE, ST_LEAD, ST_DATA} ctlState_t;
endpackage

// File: rtl/irPdCfg.sv
`timescale 1ns/1ps
module irPdCfg
  import irPdPkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [REG_W-1:0]  wrData,
  output cfg_t              cfg,
  output logic              statusClr
);
  logic [4:0]               ctrlQ;
  symWin_t                  leadQ;
  symWin_t [NUM_DSYM-1:0]   symQ;
  logic [FIELD_W-1:0]       freeQ;
  logic [MIN_LEN_W-2:0]     minHalfQ;
  logic [LEN_W-1:0]         maxRawQ;
  logic [LEN_W-1:0]         maxUp;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ctrlQ    <= '0;
      leadQ    <= '0;
      symQ     <= '0;
      freeQ    <= '0;
      minHalfQ <= '0;
      maxRawQ  <= '0;
    end else if (wrEn) begin
      if (addr == ADDR_CTRL) ctrlQ <= wrData[4:0];
      if (addr == ADDR_LEAD) leadQ <= symWin_t'(wrData);
      for (int i = 0; i < NUM_DSYM; i++)
        if (addr == ADDR_SYM0 + ADDR_W'(i)) symQ[i] <= symWin_t'(wrData);
      if (addr == ADDR_FREE) begin
        freeQ    <= wrData[FIELD_W-1:0];
        minHalfQ <= wrData[FREE_MINLEN_LSB+MIN_LEN_W-1:FREE_MINLEN_LSB+1];
        maxRawQ  <= wrData[FREE_MAXLEN_LSB+LEN_W-1:FREE_MAXLEN_LSB];
      end
    end
  end

  assign maxUp = maxRawQ + LEN_W'(1);

  always_comb begin
    cfg.decodeEn = ctrlQ[0];
    cfg.polInv   = ctrlQ[1];
    cfg.leaderEn = ctrlQ[2];
    cfg.msbFirst = ctrlQ[3];
    cfg.bitInv   = ctrlQ[4];
    cfg.lead     = leadQ;
    cfg.sym      = symQ;
    cfg.freeMin  = freeQ;
    cfg.minLen   = LEN_W'({minHalfQ, 1'b0});
    cfg.maxLen   = (maxRawQ >= LEN_W'(MAX_LEN_CAP - 1)) ? LEN_W'(MAX_LEN_CAP)
                                                         : (maxUp & ~LEN_W'(1));
  end

  assign statusClr = wrEn && (addr == ADDR_STATUS) && !wrData[0];
endmodule

// File: rtl/irPdCtrl.sv
`timescale 1ns/1ps
module irPdCtrl
  import irPdPkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       decodeEn,
  input  logic       leaderEn,
  input  logic       riseEv,
  input  logic       leadHit,
  input  logic       symHit,
  input  logic       freeHit,
  output ctlStrobe_t strobe
);
  ctlState_t state, nextState;
  ctlState_t startState;

  assign startState = leaderEn ? ST_LEAD : ST_DATA;

  always_comb begin
    nextState = state;
    strobe    = '0;
    if (!decodeEn) begin
      nextState       = ST_IDLE;
      strobe.frameClr = 1'b1;
    end else begin
      case (state)
        ST_IDLE: begin
          if (riseEv) begin
            strobe.frameClr = 1'b1;
            nextState       = startState;
          end
        end
        ST_LEAD: begin
          if (riseEv) begin
            strobe.frameClr = 1'b1;
            nextState       = leadHit ? ST_DATA : ST_LEAD;
          end else if (freeHit) begin
            nextState = ST_IDLE;
          end
        end
        ST_DATA: begin
          if (freeHit) begin
            strobe.commit = 1'b1;
            if (riseEv) begin
              strobe.frameClr = 1'b1;
              nextState       = startState;
            end else begin
              nextState = ST_IDLE;
            end
          end else if (riseEv) begin
            if (symHit) begin
              strobe.shiftEn = 1'b1;
            end else begin
              strobe.frameClr = 1'b1;
              nextState       = startState;
            end
          end
        end
        default: nextState = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= nextState;
  end

  // R10: turning decode off returns the sequencer to idle on the next edge
  p_off_idle_r10: assert property (@(posedge clk) disable iff (!rstN)
    !decodeEn |=> state == ST_IDLE);
endmodule

// File: rtl/irPdDatapath.sv
`timescale 1ns/1ps
module irPdDatapath
  import irPdPkg::*;
(
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   irIn,
  input  logic                   decodeEn,
  input  logic                   polInv,
  input  logic                   msbFirst,
  input  logic                   bitInv,
  input  symWin_t                leadWin,
  input  symWin_t [NUM_DSYM-1:0] symWin,
  input  logic [FIELD_W-1:0]     freeMin,
  input  logic [LEN_W-1:0]       minLen,
  input  logic [LEN_W-1:0]       maxLen,
  input  ctlStrobe_t             strobe,
  input  logic                   statusClr,
  output logic                   riseEv,
  output logic                   leadHit,
  output logic                   symHit,
  output logic                   freeHit,
  output logic [DATA_W-1:0]      rxData,
  output logic [LEN_W-1:0]       rxLen,
  output logic                   rxValid
);
  logic                 markQ, markD;
  logic [CNT_W-1:0]     periodCnt, widthCnt, spaceCnt;
  logic [NUM_DSYM-1:0]  hitVec;
  logic                 symBit, newBit, lenOk;
  logic [DATA_W-1:0]    shiftQ;
  logic [LEN_W-1:0]     bitCnt;

  function automatic logic [CNT_W-1:0] satInc(input logic [CNT_W-1:0] v);
    return (&v) ? v : v + CNT_W'(1);
  endfunction

  function automatic logic inWin(input logic [CNT_W-1:0] v,
                                 input logic [FIELD_W-1:0] lo,
                                 input logic [FIELD_W-1:0] hi);
    return (v >= CNT_W'(lo)) && (v <= CNT_W'(hi));
  endfunction

  // input conditioning and symbol timers
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      markQ     <= 1'b0;
      markD     <= 1'b0;
      periodCnt <= '0;
      widthCnt  <= '0;
      spaceCnt  <= '0;
    end else if (!decodeEn) begin
      markQ     <= 1'b0;
      markD     <= 1'b0;
      periodCnt <= '0;
      widthCnt  <= '0;
      spaceCnt  <= '0;
    end else begin
      markQ     <= irIn ^ polInv;
      markD     <= markQ;
      periodCnt <= riseEv ? CNT_W'(1) : satInc(periodCnt);
      widthCnt  <= riseEv ? CNT_W'(1) : (markQ ? satInc(widthCnt) : widthCnt);
      spaceCnt  <= markQ ? '0 : satInc(spaceCnt);
    end
  end

  assign riseEv  = markQ && !markD;
  assign freeHit = (spaceCnt >> FREE_SHIFT) >= CNT_W'(freeMin);
  assign leadHit = inWin(periodCnt >> LEAD_SHIFT, leadWin.pMin, leadWin.pMax) &&
                   inWin(widthCnt  >> LEAD_SHIFT, leadWin.wMin, leadWin.wMax);

  for (genvar g = 0; g < NUM_DSYM; g++) begin : gSym
    assign hitVec[g] = inWin(periodCnt >> DPER_SHIFT, symWin[g].pMin, symWin[g].pMax) &&
                       inWin(widthCnt  >> DWID_SHIFT, symWin[g].wMin, symWin[g].wMax);
  end

  // lowest matching window index decides the bit
  always_comb begin
    logic found;
    found  = 1'b0;
    symBit = 1'b0;
    for (int i = 0; i < NUM_DSYM; i++) begin
      if (hitVec[i] && !found) begin
        symBit = (i % 2) == 1;
        found  = 1'b1;
      end
    end
  end

  assign symHit = |hitVec;
  assign newBit = symBit ^ bitInv;
  assign lenOk  = (bitCnt >= minLen) && (bitCnt <= maxLen);

  // bit assembly
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shiftQ <= '0;
      bitCnt <= '0;
    end else if (strobe.frameClr) begin
      shiftQ <= '0;
      bitCnt <= '0;
    end else if (strobe.shiftEn) begin
      if (msbFirst) shiftQ <= {shiftQ[DATA_W-2:0], newBit};
      else          shiftQ[bitCnt] <= newBit;
      if (bitCnt != '1) bitCnt <= bitCnt + LEN_W'(1);
    end
  end

  // captured message
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxData  <= '0;
      rxLen   <= '0;
      rxValid <= 1'b0;
    end else if (strobe.commit && lenOk && !rxValid) begin
      rxData  <= shiftQ;
      rxLen   <= bitCnt;
      rxValid <= 1'b1;
    end else if (statusClr) begin
      rxValid <= 1'b0;
    end
  end

  // R4: a message is only closed during a free-time space
  p_commit_free_r4: assert property (@(posedge clk) disable iff (!rstN)
    strobe.commit |-> freeHit);
  // R9: valid holds until software clears it
  p_valid_hold_r9: assert property (@(posedge clk) disable iff (!rstN)
    rxValid && !statusClr |=> rxValid);
  // R9: a clear write drops the flag
  p_valid_clear_r9: assert property (@(posedge clk) disable iff (!rstN)
    statusClr && rxValid |=> !rxValid);
  // R9: captured data does not move while valid is pending
  p_data_stable_r9: assert property (@(posedge clk) disable iff (!rstN)
    rxValid |=> $stable(rxData) && $stable(rxLen));
  // R5: no captured length beyond the hard cap
  p_len_cap_r5: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rxValid) |-> rxLen <= LEN_W'(MAX_LEN_CAP));
endmodule

// File: rtl/irPdDecoder.sv
`timescale 1ns/1ps
module irPdDecoder
  import irPdPkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              irIn,
  input  logic              cfgWrEn,
  input  logic [ADDR_W-1:0] cfgAddr,
  input  logic [REG_W-1:0]  cfgWrData,
  output logic [REG_W-1:0]  rxDataLo,
  output logic [REG_W-1:0]  rxDataHi,
  output logic [LEN_W-1:0]  rxLen,
  output logic              rxValid
);
  cfg_t              cfg;
  logic              statusClr;
  ctlStrobe_t        strobe;
  logic              riseEv, leadHit, symHit, freeHit;
  logic [DATA_W-1:0] rxData;

  irPdCfg uCfg (
    .clk(clk), .rstN(rstN), .wrEn(cfgWrEn), .addr(cfgAddr),
    .wrData(cfgWrData), .cfg(cfg), .statusClr(statusClr)
  );

  irPdCtrl uCtrl (
    .clk(clk), .rstN(rstN), .decodeEn(cfg.decodeEn), .leaderEn(cfg.leaderEn),
    .riseEv(riseEv), .leadHit(leadHit), .symHit(symHit), .freeHit(freeHit),
    .strobe(strobe)
  );

  irPdDatapath uDp (
    .clk(clk), .rstN(rstN), .irIn(irIn), .decodeEn(cfg.decodeEn),
    .polInv(cfg.polInv), .msbFirst(cfg.msbFirst), .bitInv(cfg.bitInv),
    .leadWin(cfg.lead), .symWin(cfg.sym), .freeMin(cfg.freeMin),
    .minLen(cfg.minLen), .maxLen(cfg.maxLen), .strobe(strobe),
    .statusClr(statusClr), .riseEv(riseEv), .leadHit(leadHit),
    .symHit(symHit), .freeHit(freeHit), .rxData(rxData), .rxLen(rxLen),
    .rxValid(rxValid)
  );

  assign rxDataLo = rxData[REG_W-1:0];
  assign rxDataHi = rxData[DATA_W-1:REG_W];
endmodule

// File: tb/irPdDecoder_test.sv
`timescale 1ns/1ps
module irPdDecoder_test;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        irIn = 1'b0;
  logic        cfgWrEn = 1'b0;
  logic [2:0]  cfgAddr = '0;
  logic [31:0] cfgWrData = '0;
  logic [31:0] rxDataLo, rxDataHi;
  logic [5:0]  rxLen;
  logic        rxValid;

  int errors = 0;
  int checks = 0;
  bit pol = 1'b0;
  localparam logic [63:0] PAT = 64'hA5C3_1E7F_0912_6B4D;
  localparam logic [31:0] W_LEAD  = 32'h0808_0505;
  localparam logic [31:0] W_ZERO  = 32'h0907_0A06;
  localparam logic [31:0] W_ONE   = 32'h110F_0A06;
  localparam logic [31:0] W_NEVER = 32'h00FF_00FF;

  always #2.5 clk = ~clk;

  irPdDecoder uut (
    .clk(clk), .rstN(rstN), .irIn(irIn), .cfgWrEn(cfgWrEn), .cfgAddr(cfgAddr),
    .cfgWrData(cfgWrData), .rxDataLo(rxDataLo), .rxDataHi(rxDataHi),
    .rxLen(rxLen), .rxValid(rxValid)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cfgWrite(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    cfgWrEn = 1'b1; cfgAddr = a; cfgWrData = d;
    @(negedge clk);
    cfgWrEn = 1'b0;
  endtask

  task automatic level(input bit lv, input int cyc);
    irIn = lv ^ pol;
    repeat (cyc) @(negedge clk);
  endtask

  task automatic sym(input int w, input int p);
    level(1'b1, w);
    level(1'b0, p - w);
  endtask

  // badIdx selects one data symbol to be sent with width bw and period bp
  task automatic frame(input bit doLead, input int lw, input int lp, input int n,
                       input logic [63:0] b, input int badIdx, input int bw,
                       input int bp, input int tail);
    if (doLead) sym(lw, lp);
    for (int i = 0; i < n; i++) begin
      if (i == badIdx) sym(bw, bp);
      else             sym(8, b[i] ? 32 : 16);
    end
    level(1'b1, 8);
    level(1'b0, tail);
  endtask

  function automatic logic [63:0] expVal(input logic [63:0] b, input int n,
                                         input bit msb, input bit inv);
    logic [63:0] e = '0;
    for (int i = 0; i < n; i++) begin
      if (msb) e[n-1-i] = b[i] ^ inv;
      else     e[i]     = b[i] ^ inv;
    end
    return e;
  endfunction

  task automatic expectMsg(input string req, input logic [63:0] e, input int n);
    chk(req, {63'd0, rxValid}, 64'd1);
    chk(req, {32'd0, rxDataLo}, {32'd0, e[31:0]});
    chk(req, {32'd0, rxDataHi}, {32'd0, e[63:32]});
    chk(req, {58'd0, rxLen}, 64'(n));
  endtask

  task automatic stdFrame(input int n, input logic [63:0] b);
    frame(1'b1, 80, 128, n, b, -1, 0, 0, 100);
  endtask

  task automatic clearValid();
    cfgWrite(3'd7, 32'h0);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R12 reset values
    chk("R12 valid", {63'd0, rxValid}, 64'd0);
    chk("R12 lo", {32'd0, rxDataLo}, 64'd0);
    chk("R12 hi", {32'd0, rxDataHi}, 64'd0);
    chk("R12 len", {58'd0, rxLen}, 64'd0);
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    chk("R12 valid after release", {63'd0, rxValid}, 64'd0);

    cfgWrite(3'd1, W_LEAD);
    cfgWrite(3'd2, W_ZERO);
    cfgWrite(3'd3, W_ONE);
    cfgWrite(3'd4, W_NEVER);
    cfgWrite(3'd5, W_NEVER);
    cfgWrite(3'd6, 32'h003F_0508);   // free 8 units, min 4, max 48
    cfgWrite(3'd0, 32'h05);          // enable, leader on, lsb first

    // R5 / R6 / R2: length sweep, LSB first
    for (int n = 1; n <= 50; n++) begin
      stdFrame(n, PAT);
      repeat (4) @(negedge clk);
      if (n >= 4 && n <= 48) begin
        expectMsg("R5 R6 sweep", expVal(PAT, n, 1'b0, 1'b0), n);
        clearValid();
      end else begin
        chk("R5 out of range dropped", {63'd0, rxValid}, 64'd0);
      end
    end

    // R6 MSB first
    cfgWrite(3'd0, 32'h0D);
    stdFrame(20, PAT);
    repeat (4) @(negedge clk);
    expectMsg("R6 msb first", expVal(PAT, 20, 1'b1, 1'b0), 20);
    clearValid();

    // R7 bit inversion
    cfgWrite(3'd0, 32'h15);
    stdFrame(12, PAT);
    repeat (4) @(negedge clk);
    expectMsg("R7 invert", expVal(PAT, 12, 1'b0, 1'b1), 12);
    clearValid();

    // R8 input polarity
    cfgWrite(3'd0, 32'h06);
    pol = 1'b1;
    irIn = 1'b1;
    cfgWrite(3'd0, 32'h07);
    stdFrame(16, ~PAT);
    repeat (4) @(negedge clk);
    expectMsg("R8 polarity", expVal(~PAT, 16, 1'b0, 1'b0), 16);
    clearValid();
    cfgWrite(3'd0, 32'h04);
    pol = 1'b0;
    irIn = 1'b0;
    cfgWrite(3'd0, 32'h05);

    // R9 hold, ignored set-write, clear
    stdFrame(10, PAT);
    repeat (4) @(negedge clk);
    stdFrame(14, ~PAT);
    repeat (4) @(negedge clk);
    expectMsg("R9 no overwrite", expVal(PAT, 10, 1'b0, 1'b0), 10);
    cfgWrite(3'd7, 32'h1);
    chk("R9 write one ignored", {63'd0, rxValid}, 64'd1);
    clearValid();
    chk("R9 cleared", {63'd0, rxValid}, 64'd0);

    // R4 free-time threshold
    frame(1'b1, 80, 128, 8, PAT, -1, 0, 0, 56);
    chk("R4 short space no end", {63'd0, rxValid}, 64'd0);
    level(1'b0, 20);
    expectMsg("R4 end after free time", expVal(PAT, 8, 1'b0, 1'b0), 8);
    clearValid();

    // R5 edges: min field 9 -> 8, max field 11 -> 12
    cfgWrite(3'd6, 32'h000B_0908);
    for (int n = 7; n <= 13; n++) begin
      stdFrame(n, PAT);
      repeat (4) @(negedge clk);
      chk($sformatf("R5 edge n=%0d", n), {63'd0, rxValid}, 64'(n >= 8 && n <= 12));
      clearValid();
    end
    cfgWrite(3'd6, 32'h003F_0508);

    // R2 window bounds on symbol 3, R3 abort on miss
    begin
      int bw[6] = '{6, 10, 5, 11, 8, 8};
      int bp[6] = '{14, 19, 16, 16, 13, 20};
      bit ok[6] = '{1, 1, 0, 0, 0, 0};
      logic [63:0] b0 = PAT & ~64'h8;
      for (int k = 0; k < 6; k++) begin
        frame(1'b1, 80, 128, 8, b0, 3, bw[k], bp[k], 100);
        repeat (4) @(negedge clk);
        chk($sformatf("R2 R3 bound w=%0d p=%0d", bw[k], bp[k]),
            {63'd0, rxValid}, 64'(ok[k]));
        if (ok[k]) chk("R2 bound data", {32'd0, rxDataLo},
                       {32'd0, expVal(b0, 8, 1'b0, 1'b0)});
        clearValid();
      end
      stdFrame(8, PAT);
      repeat (4) @(negedge clk);
      expectMsg("R3 recovers at next leader", expVal(PAT, 8, 1'b0, 1'b0), 8);
      clearValid();
    end

    // R1 leader bounds
    begin
      int lw[4] = '{95, 96, 79, 80};
      int lp[4] = '{143, 128, 128, 144};
      bit ok[4] = '{1, 0, 0, 0};
      for (int k = 0; k < 4; k++) begin
        frame(1'b1, lw[k], lp[k], 8, PAT, -1, 0, 0, 100);
        repeat (4) @(negedge clk);
        chk($sformatf("R1 leader w=%0d p=%0d", lw[k], lp[k]),
            {63'd0, rxValid}, 64'(ok[k]));
        clearValid();
      end
    end

    // R2 overlap: window 2 equals window 1, lowest index (1 -> bit 1) wins
    cfgWrite(3'd4, W_ONE);
    stdFrame(16, PAT);
    repeat (4) @(negedge clk);
    expectMsg("R2 lowest index wins", expVal(PAT, 16, 1'b0, 1'b0), 16);
    clearValid();
    // R2 parity: only window 3 (odd) carries the long period
    cfgWrite(3'd4, W_NEVER);
    cfgWrite(3'd3, W_NEVER);
    cfgWrite(3'd5, W_ONE);
    stdFrame(16, PAT);
    repeat (4) @(negedge clk);
    expectMsg("R2 odd window gives one", expVal(PAT, 16, 1'b0, 1'b0), 16);
    clearValid();
    cfgWrite(3'd5, W_NEVER);
    cfgWrite(3'd3, W_ONE);

    // R11 leader off
    cfgWrite(3'd0, 32'h01);
    frame(1'b0, 0, 0, 16, PAT, -1, 0, 0, 100);
    repeat (4) @(negedge clk);
    expectMsg("R11 no leader", expVal(PAT, 16, 1'b0, 1'b0), 16);
    clearValid();
    // R3 with leader off: the symbol after a miss starts a new frame
    frame(1'b0, 0, 0, 12, PAT, 5, 8, 24, 100);
    repeat (4) @(negedge clk);
    expectMsg("R3 restart without leader",
              expVal(PAT >> 6, 6, 1'b0, 1'b0), 6);
    clearValid();
    cfgWrite(3'd0, 32'h05);

    // R10 captured outputs kept when decode goes off, frames ignored
    stdFrame(9, PAT);
    repeat (4) @(negedge clk);
    cfgWrite(3'd0, 32'h04);
    expectMsg("R10 outputs kept", expVal(PAT, 9, 1'b0, 1'b0), 9);
    clearValid();
    stdFrame(9, PAT);
    repeat (4) @(negedge clk);
    chk("R10 disabled ignores frame", {63'd0, rxValid}, 64'd0);
    cfgWrite(3'd0, 32'h05);
    // R10 disable in mid-frame discards the partial frame
    fork
      stdFrame(16, PAT);
      begin
        repeat (300) @(negedge clk);
        cfgWrite(3'd0, 32'h04);
        cfgWrite(3'd0, 32'h05);
      end
    join
    repeat (4) @(negedge clk);
    chk("R10 mid-frame disable", {63'd0, rxValid}, 64'd0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule